// File: doc/BRIEF.md
# Dual-Protocol Host Bus Port for a Bitmap Display Controller

This block is the host side of a bitmap display controller. A processor reaches it over one parallel bus. The bus can run either the R/W-plus-enable strobe protocol of 68-family processors or the separate read/write strobe protocol of 80-family processors, and a mode pin picks which one. A register-select line marks each access as a command or a display-data transfer.

Command writes are decoded into the controller's settings: display start line, memory page, column address and drive duty. Display-data accesses write to or read from the external display memory at the current page and column. After every data access the column moves to the next position.

Every access finishes on the block's own clock a fixed two cycles after the strobe edge is seen, so the host never polls for busy. Read data comes through a one-deep holding register, so the first read after an address change gives stale data. The memory array and the display scan are outside this block.

Top module: `host_bus_if`

## Requirements
- R1: With `busMode`=0, an access is taken on the falling edge of `enable`. `rwN`=1 makes it a read and `rwN`=0 a write. `regSel` and the write data are the values held while `enable` was high; bus changes at the falling edge itself are not used.
- R2: With `busMode`=1, a rising edge of `wrN` is a write and a rising edge of `rdN` is a read. Write data is the value held while `wrN` was low. If both strobes rise together, the access is ignored: neither memory nor column changes.
- R3: The strobes of the protocol that is not selected have no effect. In mode 0, pulses on `rdN`/`wrN` change nothing. In mode 1, pulses on `enable` change nothing.
- R4: A write with `regSel`=0 is a command decoded from bits 7:0 of the bus. Code 0ccccccc sets the column to c, and values above COLS-1 are clamped to COLS-1.
- R5: Command 110lllll sets the 5-bit start line output `startLine` to l.
- R6: Command 101000pp sets the page to pp, ignored when pp ≥ PAGES. Command 1010010d sets `dutySel` to d (0 = 16-line, 1 = 32-line duty).
- R7: Any other command code changes no setting: start line, page, column and duty all keep their values.
- R8: A write with `regSel`=1 stores the full bus word at (`memPage`, `memCol`) and then advances the column by one.
- R9: The column never exceeds COLS-1. A data access at column COLS-1 leaves it at COLS-1.
- R10: A data read returns on `busOut`, while the read strobe is active, the word that the previous data read fetched, and then fetches the word at the current address. The first read after reset returns 0.
- R11: A read with `regSel`=0 drives 0 on `busOut` and changes no setting.
- R12: After reset the start line, page, column and duty are 0, and `busOe` is 0 while no read strobe is active.
- R13: With a 16-bit bus, bits 15:8 are ignored on command writes, and data writes store all 16 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busMode | input | 1 | 0: R/W + enable protocol, 1: separate read/write strobes |
| regSel | input | 1 | 0: command, 1: display data |
| rwN | input | 1 | Mode 0 direction, 1 = read |
| enable | input | 1 | Mode 0 access enable, active high |
| rdN | input | 1 | Mode 1 read strobe, active low |
| wrN | input | 1 | Mode 1 write strobe, active low |
| busIn | input | DATA_W | Data from the host |
| busOut | output | DATA_W | Data to the host |
| busOe | output | 1 | Host bus driver enable, high during a read strobe |
| memPage | output | PAGE_W | Display memory page |
| memCol | output | COL_W | Display memory column |
| memWe | output | 1 | Memory write strobe, one cycle |
| memWrData | output | DATA_W | Memory write word |
| memRdData | input | DATA_W | Memory word at (`memPage`, `memCol`) |
| startLine | output | 5 | Display start line |
| dutySel | output | 1 | Duty select |

## Verification
The bench builds the block with DATA_W=16, COLS=80 and PAGES=4. The 16-bit width makes it possible to check that the upper byte is ignored on commands but stored on data writes. The 80-column depth puts the clamp of large column codes and the saturation at the last column within a few accesses. Four pages leave every page code valid, so the page field can be checked in full. The bench models the display memory and runs both strobe protocols against it. The cases covered are read-back through the holding register, simultaneous read and write strobes, and the strobes of the unselected protocol.

// File: rtl/host_bus_pkg.sv
package host_bus_pkg;

  localparam int LINE_W = 5;
  localparam int ARG_W  = 7;

  // Strobes from control to datapath, valid for a single cycle
  typedef struct packed {
    logic             cmdCol;
    logic             cmdLine;
    logic             cmdPage;
    logic             cmdDuty;
    logic             dataWr;
    logic             dataRd;
    logic [ARG_W-1:0] arg;
  } strobe_t;

endpackage

// File: rtl/hbi_ctrl.sv
module hbi_ctrl
  import host_bus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busMode,
  input  logic              regSel,
  input  logic              rwN,
  input  logic              enable,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] busIn,
  output strobe_t           strb,
  output logic [DATA_W-1:0] wrData,
  output logic              busOe,
  output logic              drvData
);

  // Two sampling stages: stage 1 sees the edge, stage 2 keeps the pre-edge bus
  logic enQ1, enQ2, rdQ1, rdQ2, wrQ1, wrQ2;
  logic rsQ1, rsQ2, rwQ1, rwQ2;
  logic [DATA_W-1:0] dQ1, dQ2;
  logic [7:0] cmdByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ1 <= 1'b0; enQ2 <= 1'b0;
      rdQ1 <= 1'b1; rdQ2 <= 1'b1;
      wrQ1 <= 1'b1; wrQ2 <= 1'b1;
      rsQ1 <= 1'b0; rsQ2 <= 1'b0;
      rwQ1 <= 1'b1; rwQ2 <= 1'b1;
      dQ1  <= '0;   dQ2  <= '0;
    end else begin
      enQ1 <= enable; enQ2 <= enQ1;
      rdQ1 <= rdN;    rdQ2 <= rdQ1;
      wrQ1 <= wrN;    wrQ2 <= wrQ1;
      rsQ1 <= regSel; rsQ2 <= rsQ1;
      rwQ1 <= rwN;    rwQ2 <= rwQ1;
      dQ1  <= busIn;  dQ2  <= dQ1;
    end
  end

  // Command byte: the low byte of the bus, whatever its width
  generate
    if (DATA_W == 8) begin : g_bus8
      assign cmdByte = dQ2;
    end else if (DATA_W == 16) begin : g_bus16
      assign cmdByte = dQ2[7:0];
    end else begin : g_busBad
      $error("hbi_ctrl: DATA_W must be 8 or 16");
      assign cmdByte = dQ2[7:0];
    end
  endgenerate

  logic fallEn, riseWr, riseRd;
  logic isWrite, isRead;

  always_comb begin
    fallEn = !busMode && enQ2 && !enQ1;
    riseWr = busMode && !wrQ2 && wrQ1;
    riseRd = busMode && !rdQ2 && rdQ1;
    if (fallEn) begin
      isWrite = !rwQ2;
      isRead  = rwQ2;
    end else begin
      isWrite = riseWr && !riseRd;
      isRead  = riseRd && !riseWr;
    end
  end

  // Instruction decode
  always_comb begin
    strb        = '0;
    strb.arg    = cmdByte[ARG_W-1:0];
    strb.dataWr = isWrite && rsQ2;
    strb.dataRd = isRead && rsQ2;
    if (isWrite && !rsQ2) begin
      if (!cmdByte[7])                      strb.cmdCol  = 1'b1;
      else if (cmdByte[7:5] == 3'b110)      strb.cmdLine = 1'b1;
      else if (cmdByte[7:2] == 6'b101000)   strb.cmdPage = 1'b1;
      else if (cmdByte[7:1] == 7'b1010010)  strb.cmdDuty = 1'b1;
    end
  end

  assign wrData  = dQ2;
  assign busOe   = busMode ? !rdN : (enable && rwN);
  assign drvData = busOe && regSel;

  // R1
  edge68_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busMode && $past(!busMode) && $past(!busMode, 2) &&
     (strb.dataWr || strb.dataRd || strb.cmdCol || strb.cmdLine ||
      strb.cmdPage || strb.cmdDuty))
    |-> (!$past(enable) && $past(enable, 2)));

endmodule

// File: rtl/hbi_datapath.sv
module hbi_datapath
  import host_bus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COLS   = 80,
  parameter int PAGES  = 4,
  localparam int COL_W  = $clog2(COLS),
  localparam int PAGE_W = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              drvData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] busOut,
  output logic [PAGE_W-1:0] memPage,
  output logic [COL_W-1:0]  memCol,
  output logic              memWe,
  output logic [DATA_W-1:0] memWrData,
  output logic [LINE_W-1:0] startLine,
  output logic              dutySel
);

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

  logic [DATA_W-1:0] rdHold;
  logic              dataAcc;

  assign dataAcc = strb.dataWr || strb.dataRd;

  // Address counter: loaded by command, stepped by data accesses
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCol <= '0;
    end else if (strb.cmdCol) begin
      if (int'(strb.arg) > COLS - 1) memCol <= COL_LAST;
      else                           memCol <= COL_W'(strb.arg);
    end else if (dataAcc && memCol != COL_LAST) begin
      memCol <= memCol + COL_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memPage   <= '0;
      startLine <= '0;
      dutySel   <= 1'b0;
    end else begin
      if (strb.cmdPage && int'(strb.arg[1:0]) < PAGES)
        memPage <= PAGE_W'(strb.arg[1:0]);
      if (strb.cmdLine)
        startLine <= strb.arg[LINE_W-1:0];
      if (strb.cmdDuty)
        dutySel <= strb.arg[0];
    end
  end

  // One-deep read holding register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdHold <= '0;
    else if (strb.dataRd) rdHold <= memRdData;
  end

  assign busOut    = drvData ? rdHold : '0;
  assign memWe     = strb.dataWr;
  assign memWrData = wrData;

  // R9
  col_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    memCol <= COL_LAST);

  // R9
  col_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && !strb.cmdCol && memCol == COL_LAST) |=> memCol == COL_LAST);

  // R8
  col_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && !strb.cmdCol && memCol != COL_LAST)
    |=> memCol == $past(memCol) + COL_W'(1));

  // R7
  line_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cmdLine |=> $stable(startLine));

endmodule

// File: rtl/host_bus_if.sv
module host_bus_if
  import host_bus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int COLS   = 80,
  parameter int PAGES  = 4,
  localparam int COL_W  = $clog2(COLS),
  localparam int PAGE_W = $clog2(PAGES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busMode,
  input  logic              regSel,
  input  logic              rwN,
  input  logic              enable,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] busIn,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [PAGE_W-1:0] memPage,
  output logic [COL_W-1:0]  memCol,
  output logic              memWe,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [LINE_W-1:0] startLine,
  output logic              dutySel
);

  strobe_t           strb;
  logic [DATA_W-1:0] wrData;
  logic              drvData;

  hbi_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busMode(busMode), .regSel(regSel), .rwN(rwN),
    .enable(enable), .rdN(rdN), .wrN(wrN), .busIn(busIn),
    .strb(strb), .wrData(wrData), .busOe(busOe), .drvData(drvData)
  );

  hbi_datapath #(.DATA_W(DATA_W), .COLS(COLS), .PAGES(PAGES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .drvData(drvData),
    .memRdData(memRdData), .busOut(busOut), .memPage(memPage), .memCol(memCol),
    .memWe(memWe), .memWrData(memWrData), .startLine(startLine),
    .dutySel(dutySel)
  );

endmodule

// File: tb/host_bus_if_bench.sv
module host_bus_if_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NCOL = 80;
  localparam int NPAGE = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic busMode = 1'b0, regSel = 1'b0, rwN = 1'b1, enable = 1'b0;
  logic rdN = 1'b1, wrN = 1'b1;
  logic [DW-1:0] busIn = '0, busOut, memWrData, memRdData;
  logic busOe, memWe, dutySel;
  logic [1:0] memPage;
  logic [6:0] memCol;
  logic [4:0] startLine;
  logic [DW-1:0] mem [NPAGE*NCOL];
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_bus_if #(.DATA_W(DW), .COLS(NCOL), .PAGES(NPAGE)) u_host_bus_if (
    .clk(clk), .rstN(rstN), .busMode(busMode), .regSel(regSel), .rwN(rwN),
    .enable(enable), .rdN(rdN), .wrN(wrN), .busIn(busIn), .busOut(busOut),
    .busOe(busOe), .memPage(memPage), .memCol(memCol), .memWe(memWe),
    .memWrData(memWrData), .memRdData(memRdData), .startLine(startLine),
    .dutySel(dutySel)
  );

  assign memRdData = mem[int'(memPage) * NCOL + int'(memCol)];
  always @(posedge clk) if (memWe) mem[int'(memPage) * NCOL + int'(memCol)] <= memWrData;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic rs, input logic rd, input logic [DW-1:0] d,
                        output logic [DW-1:0] q);
    @(negedge clk);
    regSel = rs; busIn = d;
    if (!busMode) begin rwN = rd; enable = 1'b1; end
    else if (rd) rdN = 1'b0;
    else wrN = 1'b0;
    repeat (2) @(negedge clk);
    q = busOut;
    if (!busMode) enable = 1'b0;
    else begin rdN = 1'b1; wrN = 1'b1; end
    busIn = ~d;
    regSel = ~rs;
    repeat (3) @(negedge clk);
  endtask

  task automatic cmd(input logic [DW-1:0] c);
    logic [DW-1:0] q;
    access(1'b0, 1'b0, c, q);
  endtask

  task automatic wdata(input logic [DW-1:0] d);
    logic [DW-1:0] q;
    access(1'b1, 1'b0, d, q);
  endtask

  task automatic test_reset();
    check("R12 startLine", startLine, 0);
    check("R12 page", memPage, 0);
    check("R12 column", memCol, 0);
    check("R12 duty", dutySel, 0);
    check("R12 busOe", busOe, 0);
  endtask

  task automatic test_commands();
    busMode = 1'b0;
    cmd(16'h00D5); check("R5 R1 start line", startLine, 21);
    cmd(16'h00A5); check("R6 duty", dutySel, 1);
    cmd(16'h00A2); check("R6 page", memPage, 2);
    cmd(16'h0005); check("R4 column", memCol, 5);
    cmd(16'h007F); check("R4 column clamp", memCol, 79);
  endtask

  task automatic test_unknown();
    cmd(16'h00E7); cmd(16'h00A8); cmd(16'h00A7);
    check("R7 line kept", startLine, 21);
    check("R7 page kept", memPage, 2);
    check("R7 column kept", memCol, 79);
    check("R7 duty kept", dutySel, 1);
  endtask

  task automatic test_write68();
    cmd(16'h00A1); cmd(16'h000A);
    wdata(16'hBEEF); wdata(16'h1234);
    check("R8 R13 word 10", mem[90], 16'hBEEF);
    check("R8 word 11", mem[91], 16'h1234);
    check("R8 column step", memCol, 12);
  endtask

  task automatic test_saturate();
    cmd(16'h004E);
    wdata(16'h1111); wdata(16'h2222); wdata(16'h3333);
    check("R9 word 78", mem[158], 16'h1111);
    check("R9 word 79", mem[159], 16'h3333);
    check("R9 column held", memCol, 79);
  endtask

  task automatic test_read80();
    logic [DW-1:0] q;
    busMode = 1'b1;
    cmd(16'h000A);
    access(1'b1, 1'b1, '0, q); check("R10 dummy read", q, 0);
    access(1'b1, 1'b1, '0, q); check("R10 R2 read 1", q, 16'hBEEF);
    access(1'b1, 1'b1, '0, q); check("R10 R2 read 2", q, 16'h1234);
    check("R8 column after reads", memCol, 13);
  endtask

  task automatic test_write80();
    cmd(16'h00A3); cmd(16'h0000);
    wdata(16'hCAFE);
    check("R2 write 80", mem[240], 16'hCAFE);
    check("R2 column", memCol, 1);
  endtask

  task automatic test_dual();
    @(negedge clk);
    regSel = 1'b1; busIn = 16'h5555; rdN = 1'b0; wrN = 1'b0;
    repeat (2) @(negedge clk);
    rdN = 1'b1; wrN = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 dual column", memCol, 1);
    check("R2 dual memory", mem[241], 0);
  endtask

  task automatic test_other_pins();
    @(negedge clk);
    regSel = 1'b0; rwN = 1'b0; busIn = 16'h0040; enable = 1'b1;
    repeat (2) @(negedge clk); enable = 1'b0;
    repeat (3) @(negedge clk);
    check("R3 enable in mode 1", memCol, 1);
    busMode = 1'b0;
    @(negedge clk); wrN = 1'b0;
    repeat (2) @(negedge clk); wrN = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 wrN in mode 0", memCol, 1);
    regSel = 1'b1; rdN = 1'b0;
    repeat (2) @(negedge clk); rdN = 1'b1;
    repeat (3) @(negedge clk);
    check("R3 rdN in mode 0", memCol, 1);
  endtask

  task automatic test_cmd_read();
    logic [DW-1:0] q;
    access(1'b0, 1'b1, 16'h00D0, q);
    check("R11 command read data", q, 0);
    check("R11 column kept", memCol, 1);
    check("R11 line kept", startLine, 21);
  endtask

  task automatic test_wide_cmd();
    cmd(16'hFFC3);
    check("R13 upper byte ignored", startLine, 3);
  endtask

  initial begin
    for (int i = 0; i < NPAGE*NCOL; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    test_reset();
    test_commands();
    test_unknown();
    test_write68();
    test_saturate();
    test_read80();
    test_write80();
    test_dual();
    test_other_pins();
    test_cmd_read();
    test_wide_cmd();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule